// File: doc/BRIEF.md
# Embedded video sync decoder

The decoder sits on an 8-bit video byte stream whose line and field timing is carried inside the data as timing reference codes rather than on separate wires. Each code is a three-byte preamble (0xFF, 0x00, 0x00) followed by a status byte. The block finds these codes and rebuilds the horizontal and vertical sync levels from them. It marks the active pixel bytes with a valid strobe. It also checks that start-of-active-video (SAV) and end-of-active-video (EAV) codes alternate. Lines may be ordered either way: EAV first, then blanking, SAV and the pixels; or SAV first, then the pixels, EAV and blanking.

A capture-start pulse arms the capture. The block then waits for the first active-line SAV that follows vertical blanking, and passes pixels from that point on. In snapshot mode it stops after one frame and raises frame-done. In continuous mode it goes on to the next frame. A bad protection field or a broken SAV/EAV alternation raises a sticky error flag, and pixel output stops until the next capture-start pulse. Pixel bytes come out four clock cycles after they enter. This delay lets the preamble bytes be removed before they could be marked valid.

The capture controller has four states. CAP_IDLE holds after reset or an error. CAP_WAIT looks for vertical blanking and then a frame start. CAP_RUN passes pixels. CAP_DONE holds after a snapshot frame ends. The transitions are:
- start: any state to CAP_WAIT on capture-start.
- fault: any state to CAP_IDLE on an error.
- frame start: CAP_WAIT to CAP_RUN on an SAV with V=0 once a V=1 code has been seen.
- snapshot end: CAP_RUN to CAP_DONE on a V=1 code when snapshot is enabled.
- rearm: CAP_RUN to CAP_WAIT on a V=1 code when snapshot is disabled.

The order checker has three states: ORD_ANY, ORD_WANT_EAV and ORD_WANT_SAV. An accepted SAV moves it to ORD_WANT_EAV and an accepted EAV moves it to ORD_WANT_SAV.

Top module: `embsync_decoder`

## Requirements
- R1: A timing code is recognised only when the bytes 0xFF, 0x00, 0x00 are followed by a status byte with bit 7 = 1. Status bit 6 is the field bit F, bit 5 is the blanking bit V, and bit 4 is H (0 = SAV, 1 = EAV). The same three bytes followed by a byte with bit 7 = 0 are ordinary data.
- R2: Status bits 3..0 must equal {V^H, F^H, F^V, F^V^H}. On a mismatch, sync_err is set and the code is ignored: hsync, vsync and the order state stay unchanged.
- R3: hsync goes high in the cycle after an EAV status byte is sampled and low in the cycle after an SAV status byte is sampled. vsync takes the V bit of the last accepted code.
- R4: Accepted codes must alternate between SAV and EAV. The first code after reset may be either kind. A repeated SAV or a repeated EAV sets sync_err.
- R5: With EAV-first lines, no error is raised. Exactly the bytes between each active-line SAV and the next EAV come out on pix_data with pix_valid, in arrival order.
- R6: With SAV-first lines, no error is raised, and the captured pixels are the same as in R5.
- R7: Preamble bytes, status bytes, horizontal-blanking bytes and all bytes of V=1 lines never appear with pix_valid high.
- R8: After capture-start, capture begins only at the first SAV with V=0 that follows a code with V=1. Active lines seen before that are not captured.
- R9: When snap_en is 1, the first V=1 code after capture began ends the frame. frame_done then goes high, and no further pixel is output until the next capture-start.
- R10: When snap_en is 0, successive frames are all captured and frame_done stays low.
- R11: sync_err is sticky and blocks pix_valid. A capture-start pulse clears sync_err and frame_done and returns the block to waiting for a frame start.
- R12: During reset, pix_valid, hsync, vsync, frame_done and sync_err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | DW (8) | Incoming video byte |
| cap_start | input | 1 | One-cycle pulse that arms capture and clears flags |
| snap_en | input | 1 | 1 = stop after one frame, 0 = capture continuously |
| pix_data | output | DW (8) | Delayed video byte |
| pix_valid | output | 1 | pix_data is an active pixel of a captured frame |
| hsync | output | 1 | High from EAV to the following SAV |
| vsync | output | 1 | V bit of the last accepted code |
| frame_done | output | 1 | Snapshot frame finished |
| sync_err | output | 1 | Sticky sync-sequence or protection error |

## Verification
The hardest case to reach from the ports is a mid-frame entry. Capture is armed while active lines are already flowing, so the block must skip them and still lock onto the next frame. The stimulus gets there by pulsing capture-start directly before a run of V=0 lines that has no blanking ahead of it, and then following with a full frame. A related case is recovery after an order fault. The bench sends two SAV codes back to back, keeps feeding complete frames that must produce no pixels, and then re-arms. It also checks that a data pattern imitating a preamble inside active video passes through as pixels.

// File: rtl/emb_sync_pkg.sv
package emb_sync_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_WAIT,
        CAP_RUN,
        CAP_DONE
    } cap_state_e;

    typedef enum logic [1:0] {
        ORD_ANY,
        ORD_WANT_EAV,
        ORD_WANT_SAV
    } ord_state_e;

    // Decoded view of the byte currently on the input
    typedef struct packed {
        logic hit;  // preamble seen and status marker bit set
        logic ok;   // hit and protection field consistent
        logic v;    // vertical blanking
        logic h;    // 1 = end of active video
    } trc_code_t;

    function automatic logic [3:0] trc_prot(input logic f, input logic v, input logic h);
        return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/trc_pipe.sv
module trc_pipe
    import emb_sync_pkg::*;
#(
    parameter int DW      = 8,
    parameter int PRE_LEN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic          act_in,
    output trc_code_t     code,
    output logic [DW-1:0] pix_data,
    output logic          pix_flag
);
    localparam int DEPTH = PRE_LEN + 1;
    localparam int B_MRK = DW - 1;
    localparam int B_F   = DW - 2;
    localparam int B_V   = DW - 3;
    localparam int B_H   = DW - 4;
    localparam int B_P   = DW - 5;

    logic [DW-1:0]      byte_q [DEPTH];
    logic [DEPTH-1:0]   flag_q;
    logic [PRE_LEN-1:0] pre_match;

    // byte_q[0] is the newest byte; the oldest preamble byte must be all ones
    generate
        for (genvar i = 0; i < PRE_LEN; i++) begin : g_pre
            if (i == PRE_LEN - 1) begin : g_lead
                assign pre_match[i] = (byte_q[i] == {DW{1'b1}});
            end else begin : g_zero
                assign pre_match[i] = (byte_q[i] == '0);
            end
        end
    endgenerate

    always_comb begin
        code.hit = (&pre_match) && din[B_MRK];
        code.v   = din[B_V];
        code.h   = din[B_H];
        code.ok  = code.hit && (din[B_P -: 4] == trc_prot(din[B_F], din[B_V], din[B_H]));
    end

    // Delay line: a detected code clears the flags of its own bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) byte_q[i] <= '0;
            flag_q <= '0;
        end else begin
            byte_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) byte_q[i] <= byte_q[i-1];
            if (code.hit) flag_q <= '0;
            else          flag_q <= {flag_q[DEPTH-2:0], act_in};
        end
    end

    assign pix_data = byte_q[DEPTH-1];
    assign pix_flag = flag_q[DEPTH-1];

endmodule

// File: rtl/seq_order.sv
module seq_order
    import emb_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trc_code_t code,
    output logic      order_viol,
    output logic      hsync,
    output logic      vsync
);
    ord_state_e state_q, state_d;
    logic       take;

    assign take = code.hit && code.ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ORD_ANY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        order_viol = 1'b0;
        if (take) begin
            unique case (state_q)
                ORD_ANY:      order_viol = 1'b0;
                ORD_WANT_EAV: order_viol = !code.h;
                ORD_WANT_SAV: order_viol = code.h;
                default:      order_viol = 1'b0;
            endcase
            state_d = code.h ? ORD_WANT_SAV : ORD_WANT_EAV;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hsync <= 1'b0;
            vsync <= 1'b0;
        end else if (take) begin
            hsync <= code.h;
            vsync <= code.v;
        end
    end

    // R3
    hsync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync) |-> $past(code.ok && code.h));

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import emb_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trc_code_t code,
    input  logic      order_viol,
    input  logic      cap_start,
    input  logic      snap_en,
    output logic      act,
    output logic      frame_done,
    output logic      sync_err
);
    cap_state_e state_q, state_d;
    logic       seen_vb_q, seen_vb_d;
    logic       in_line_q, in_line_d;
    logic       err_q, err_d;
    logic       err_set;

    assign err_set = (code.hit && !code.ok) || order_viol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= CAP_IDLE;
            seen_vb_q <= 1'b0;
            in_line_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            seen_vb_q <= seen_vb_d;
            in_line_q <= in_line_d;
            err_q     <= err_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        seen_vb_d = seen_vb_q;
        in_line_d = in_line_q;
        err_d     = err_q;
        if (cap_start) begin
            state_d   = CAP_WAIT;
            seen_vb_d = 1'b0;
            in_line_d = 1'b0;
            err_d     = 1'b0;
        end else if (err_set) begin
            state_d   = CAP_IDLE;
            in_line_d = 1'b0;
            err_d     = 1'b1;
        end else if (code.ok) begin
            unique case (state_q)
                CAP_IDLE, CAP_DONE: state_d = state_q;
                CAP_WAIT: begin
                    if (code.v) begin
                        seen_vb_d = 1'b1;
                    end else if (!code.h && seen_vb_q) begin
                        state_d   = CAP_RUN;
                        in_line_d = 1'b1;
                    end
                end
                CAP_RUN: begin
                    if (code.v) begin
                        in_line_d = 1'b0;
                        if (snap_en) begin
                            state_d = CAP_DONE;
                        end else begin
                            state_d   = CAP_WAIT;
                            seen_vb_d = 1'b1;
                        end
                    end else begin
                        in_line_d = !code.h;
                    end
                end
                default: state_d = CAP_IDLE;
            endcase
        end
    end

    always_comb begin
        act        = (state_q == CAP_RUN) && in_line_q && !err_q;
        frame_done = (state_q == CAP_DONE);
        sync_err   = err_q;
    end

    // R8
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == CAP_RUN) |-> $past(code.ok && !code.v && !code.h));

    // R11
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_start |=> (!sync_err && !frame_done));

endmodule

// File: rtl/embsync_decoder.sv
module embsync_decoder
    import emb_sync_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic          cap_start,
    input  logic          snap_en,
    output logic [DW-1:0] pix_data,
    output logic          pix_valid,
    output logic          hsync,
    output logic          vsync,
    output logic          frame_done,
    output logic          sync_err
);
    trc_code_t code;
    logic      order_viol;
    logic      act;
    logic      pix_flag;

    trc_pipe #(.DW(DW), .PRE_LEN(3)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .act_in   (act),
        .code     (code),
        .pix_data (pix_data),
        .pix_flag (pix_flag)
    );

    seq_order u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .code       (code),
        .order_viol (order_viol),
        .hsync      (hsync),
        .vsync      (vsync)
    );

    cap_ctrl u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .code       (code),
        .order_viol (order_viol),
        .cap_start  (cap_start),
        .snap_en    (snap_en),
        .act        (act),
        .frame_done (frame_done),
        .sync_err   (sync_err)
    );

    assign pix_valid = pix_flag && !sync_err;

    // R4
    order_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (order_viol && !cap_start) |=> sync_err);

    // R2
    bad_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code.hit && !code.ok && !cap_start) |=> (sync_err && $stable(hsync) && $stable(vsync)));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !pix_valid);

endmodule

// File: tb/embsync_decoder_bench.sv
module embsync_decoder_bench;

    localparam int BLANK = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] din;
    logic       cap_start;
    logic       snap_en;
    logic [7:0] pix_data;
    logic       pix_valid, hsync, vsync, frame_done, sync_err;

    always #10 clk = ~clk;  // 50 MHz

    embsync_decoder u_embsync_decoder (
        .clk(clk), .rst_n(rst_n), .din(din), .cap_start(cap_start), .snap_en(snap_en),
        .pix_data(pix_data), .pix_valid(pix_valid), .hsync(hsync), .vsync(vsync),
        .frame_done(frame_done), .sync_err(sync_err)
    );

    int         n_checks = 0;
    int         n_err    = 0;
    logic [7:0] exp_q[$];
    logic [7:0] mon_exp;
    string      cur_req  = "R5";
    bit         done     = 1'b0;

    task automatic check_eq(input string req, input string what, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: pops expected pixels as the design emits them
    always @(negedge clk) begin
        if (rst_n === 1'b1 && pix_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_err++;
                $display("FAIL %s unexpected pixel actual=%0h expected=none", cur_req, pix_data);
            end else begin
                mon_exp = exp_q.pop_front();
                check_eq(cur_req, "pixel", pix_data, mon_exp);
            end
        end
    end

    task automatic put(input logic [7:0] b);
        din = b;
        @(negedge clk);
    endtask

    task automatic put_code(input bit f, input bit v, input bit h, input bit corrupt = 1'b0);
        logic [3:0] p;
        p = {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
        if (corrupt) p = ~p;
        put(8'hFF); put(8'h00); put(8'h00); put({1'b1, f, v, h, p});
    endtask

    task automatic cap();
        din = 8'h10;
        cap_start = 1'b1;
        @(negedge clk);
        cap_start = 1'b0;
    endtask

    task automatic blank_run();
        for (int i = 0; i < BLANK; i++) put(i[0] ? 8'h10 : 8'h80);
    endtask

    task automatic payload(input bit v, input int n, input int base, input bit expect_pix, input bit pseudo);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            b = v ? 8'h80 : (8'h20 + 8'((base + i) % 200));
            if (!v && expect_pix) exp_q.push_back(b);
            put(b);
        end
        if (pseudo && !v) begin
            // R1: look-alike preamble with marker bit clear stays pixel data
            if (expect_pix) begin
                exp_q.push_back(8'hFF); exp_q.push_back(8'h00);
                exp_q.push_back(8'h00); exp_q.push_back(8'h45);
            end
            put(8'hFF); put(8'h00); put(8'h00); put(8'h45);
        end
    endtask

    task automatic line_eav(input bit v, input int n, input int base, input bit expect_pix, input bit pseudo);
        put_code(1'b0, v, 1'b1);
        check_eq("R3", "hsync after EAV", hsync, 1);
        check_eq("R3", "vsync level", vsync, v);
        blank_run();
        put_code(1'b0, v, 1'b0);
        check_eq("R3", "hsync after SAV", hsync, 0);
        payload(v, n, base, expect_pix, pseudo);
    endtask

    task automatic line_sav(input bit v, input int n, input int base, input bit expect_pix);
        put_code(1'b0, v, 1'b0);
        check_eq("R3", "hsync after SAV", hsync, 0);
        check_eq("R3", "vsync level", vsync, v);
        payload(v, n, base, expect_pix, 1'b0);
        put_code(1'b0, v, 1'b1);
        check_eq("R3", "hsync after EAV", hsync, 1);
        blank_run();
    endtask

    task automatic frame_eav(input int nvb, input int nact, input int len, input bit expect_pix, input bit pseudo = 1'b0);
        for (int i = 0; i < nvb; i++) line_eav(1'b1, len, 0, 1'b0, 1'b0);
        for (int i = 0; i < nact; i++) line_eav(1'b0, len, i * 7, expect_pix, pseudo && (i == 0));
    endtask

    task automatic frame_sav(input int nvb, input int nact, input int len, input bit expect_pix);
        for (int i = 0; i < nvb; i++) line_sav(1'b1, len, 0, 1'b0);
        for (int i = 0; i < nact; i++) line_sav(1'b0, len, i * 11 + 3, expect_pix);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        din = 8'h00;
        cap_start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_q.delete();
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        snap_en = 1'b1;
        rst_n = 1'b0;
        din = 8'h00;
        cap_start = 1'b0;
        repeat (2) @(negedge clk);
        // R12: reset state
        check_eq("R12", "pix_valid in reset", pix_valid, 0);
        check_eq("R12", "hsync in reset", hsync, 0);
        check_eq("R12", "vsync in reset", vsync, 0);
        check_eq("R12", "frame_done in reset", frame_done, 0);
        check_eq("R12", "sync_err in reset", sync_err, 0);
        do_reset();

        // R5 EAV-first snapshot, then R9 stop after one frame
        cur_req = "R5";
        cap();
        frame_eav(2, 3, 6, 1'b1);
        check_eq("R9", "frame_done while running", frame_done, 0);
        cur_req = "R9";
        frame_eav(2, 3, 6, 1'b0);
        drain();
        check_eq("R9", "frame_done after snapshot", frame_done, 1);
        check_eq("R5", "sync_err with EAV-first lines", sync_err, 0);
        check_eq("R5", "pixels left over", exp_q.size(), 0);

        // R8: armed mid-stream, active lines without prior blanking are skipped
        cur_req = "R8";
        cap();
        frame_eav(0, 2, 5, 1'b0);
        frame_eav(1, 2, 5, 1'b1, 1'b1);
        frame_eav(1, 0, 0, 1'b0);
        drain();
        check_eq("R8", "frame_done after late arm", frame_done, 1);
        check_eq("R8", "pixels left over", exp_q.size(), 0);
        check_eq("R1", "no error from look-alike preamble", sync_err, 0);

        // R10: continuous capture
        cur_req = "R10";
        snap_en = 1'b0;
        cap();
        frame_eav(1, 2, 4, 1'b1);
        frame_eav(1, 2, 4, 1'b1);
        frame_eav(1, 0, 0, 1'b0);
        drain();
        check_eq("R10", "frame_done in continuous mode", frame_done, 0);
        check_eq("R10", "pixels left over", exp_q.size(), 0);
        snap_en = 1'b1;

        // R2: bad protection bits
        cur_req = "R2";
        put_code(1'b0, 1'b1, 1'b1, 1'b1);
        check_eq("R2", "sync_err after bad protection", sync_err, 1);
        check_eq("R2", "hsync unchanged by ignored code", hsync, 0);
        cap();
        check_eq("R11", "sync_err cleared by capture-start", sync_err, 0);

        // R4: repeated SAV, then R11 suppression and recovery
        cur_req = "R4";
        put_code(1'b0, 1'b1, 1'b1);
        blank_run();
        put_code(1'b0, 1'b1, 1'b0);
        check_eq("R4", "sync_err after single SAV", sync_err, 0);
        put_code(1'b0, 1'b1, 1'b0);
        check_eq("R4", "sync_err after repeated SAV", sync_err, 1);
        cur_req = "R11";
        frame_eav(1, 2, 4, 1'b0);
        frame_eav(1, 0, 0, 1'b0);
        drain();
        check_eq("R11", "sync_err sticky", sync_err, 1);
        cap();
        check_eq("R11", "sync_err after capture-start", sync_err, 0);
        check_eq("R11", "frame_done after capture-start", frame_done, 0);
        frame_eav(1, 2, 4, 1'b1);
        frame_eav(1, 0, 0, 1'b0);
        drain();
        check_eq("R11", "frame_done after recovery", frame_done, 1);
        check_eq("R11", "pixels left over", exp_q.size(), 0);

        // R6: SAV-first ordering; R7 blanking and codes never emitted
        do_reset();
        cur_req = "R6";
        cap();
        frame_sav(1, 3, 5, 1'b1);
        frame_sav(1, 0, 0, 1'b0);
        drain();
        check_eq("R6", "frame_done SAV-first", frame_done, 1);
        check_eq("R6", "sync_err SAV-first", sync_err, 0);
        check_eq("R7", "pixels left over", exp_q.size(), 0);

        finish_run();
    end

endmodule